// File: doc/BRIEF.md
# Register rename map with free-register queue

This block is the rename step of an out-of-order core. Each logical register is held in one entry of a larger physical register file. A map table records which physical register currently holds the value of each logical register. For every incoming instruction, the block looks up the two source operands in the map and returns their physical numbers. If the instruction writes a register, the block takes a fresh physical register from a queue of unused ones and points the destination at it. It also returns the physical register that the destination replaces, so that later stages can release it once no older reader needs it. Giving every write a new register removes write-after-read and write-after-write conflicts between instructions.

A separate release port puts physical registers back at the tail of the queue, one per cycle. All lookups are combinational in the cycle the instruction is offered. The map table and the queue update on the clock edge that accepts the instruction.

A small controller has two states. Reset enters `RN_FILL`, where the controller writes the spare registers into the queue one per cycle, in ascending order. The controller moves from `RN_FILL` to `RN_RUN` on the edge that writes the last spare register, which is register NUM_PHYS-1. It stays in `RN_RUN` until the next reset.

Top module: `rn_rename`

## Requirements
- R1: After reset, `ren_ready` stays low for exactly NUM_PHYS-NUM_LOG cycles while the queue is filled. It then goes high.
- R2: After reset, logical register i is translated to physical register i.
- R3: After reset, successive allocations return physical registers NUM_LOG, NUM_LOG+1, and so on, in ascending order.
- R4: `ren_phys_a` and `ren_phys_b` give the current mapping of the source registers. When a source equals the destination of the same instruction, the source gets the mapping from before the update.
- R5: An accepted instruction with a destination returns the head of the queue on `ren_new_dst` and the replaced mapping on `ren_old_dst`. Later reads of that logical register return the new register.
- R6: An accepted instruction without a destination changes no mapping and consumes no register. The next allocation returns the same register it would have returned otherwise.
- R7: When the queue is empty, `ren_ready` is low for an instruction that has a destination and high for one that has none. A release in that same cycle does not lift the stall until the next cycle.
- R8: Released registers are handed out again in first-in first-out order, after the registers already in the queue.
- R9: When `ren_valid` is low, no mapping changes and no register is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ren_valid | input | 1 | An instruction is offered for rename |
| ren_src_a | input | $clog2(NUM_LOG) | First source logical register |
| ren_src_b | input | $clog2(NUM_LOG) | Second source logical register |
| ren_has_dst | input | 1 | The instruction writes a register |
| ren_dst | input | $clog2(NUM_LOG) | Destination logical register |
| ren_ready | output | 1 | The offered instruction can be accepted this cycle |
| ren_phys_a | output | $clog2(NUM_PHYS) | Physical register for the first source |
| ren_phys_b | output | $clog2(NUM_PHYS) | Physical register for the second source |
| ren_new_dst | output | $clog2(NUM_PHYS) | Fresh physical register for the destination |
| ren_old_dst | output | $clog2(NUM_PHYS) | Physical register previously mapped to the destination |
| rel_valid | input | 1 | A physical register is being released |
| rel_phys | input | $clog2(NUM_PHYS) | Physical register being released |

## Verification
The bench builds the block with NUM_LOG=4 and NUM_PHYS=8. With these values the queue holds only four spare registers. A few allocations are then enough to empty it, so the bench can test the stall, a release arriving during the stall, and the reuse of released registers within a short table of vectors. The short fill phase also makes it cheap to count the exact number of not-ready cycles after reset, both at the start and after a second reset in the middle of the run.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [0:0] {
        RN_FILL = 1'b0,
        RN_RUN  = 1'b1
    } rn_state_e;
endpackage

// File: rtl/rn_ctrl.sv
module rn_ctrl #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic                        filling,
    output logic                        fill_push,
    output logic [$clog2(NUM_PHYS)-1:0] fill_reg
);
    import rn_pkg::*;

    localparam int PW = $clog2(NUM_PHYS);
    localparam logic [PW-1:0] FIRST_SPARE = PW'(NUM_LOG);
    localparam logic [PW-1:0] LAST_SPARE  = PW'(NUM_PHYS - 1);

    rn_state_e     state_q, state_d;
    logic [PW-1:0] idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RN_FILL;
            idx_q   <= FIRST_SPARE;
        end else begin
            state_q <= state_d;
            if (state_q == RN_FILL) idx_q <= idx_q + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        filling   = 1'b0;
        fill_push = 1'b0;
        fill_reg  = idx_q;
        unique case (state_q)
            RN_FILL: begin
                filling   = 1'b1;
                fill_push = 1'b1;
                if (idx_q == LAST_SPARE) state_d = RN_RUN;
            end
            RN_RUN: begin
                state_d = RN_RUN;
            end
            default: state_d = RN_FILL;
        endcase
    end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int NUM_PHYS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [$clog2(NUM_PHYS)-1:0] push_reg,
    input  logic                        pop,
    output logic [$clog2(NUM_PHYS)-1:0] head_reg,
    output logic                        empty,
    output logic [$clog2(NUM_PHYS):0]   count
);
    localparam int PW = $clog2(NUM_PHYS);
    localparam int CW = PW + 1;

    logic [PW-1:0] slots [NUM_PHYS];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) slots[wr_q] <= push_reg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    assign head_reg = slots[rd_q];
    assign empty    = (cnt_q == '0);
    assign count    = cnt_q;
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_LOG)-1:0]  rd_a,
    input  logic [$clog2(NUM_LOG)-1:0]  rd_b,
    input  logic [$clog2(NUM_LOG)-1:0]  rd_d,
    output logic [$clog2(NUM_PHYS)-1:0] q_a,
    output logic [$clog2(NUM_PHYS)-1:0] q_b,
    output logic [$clog2(NUM_PHYS)-1:0] q_d,
    input  logic                        we,
    input  logic [$clog2(NUM_LOG)-1:0]  wa,
    input  logic [$clog2(NUM_PHYS)-1:0] wd
);
    localparam int PW = $clog2(NUM_PHYS);

    logic [PW-1:0] map_q [NUM_LOG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LOG; i++) map_q[i] <= PW'(i);
        end else if (we) begin
            map_q[wa] <= wd;
        end
    end

    // reads see the table before this cycle's write
    assign q_a = map_q[rd_a];
    assign q_b = map_q[rd_b];
    assign q_d = map_q[rd_d];
endmodule

// File: rtl/rn_rename.sv
module rn_rename #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ren_valid,
    input  logic [$clog2(NUM_LOG)-1:0]  ren_src_a,
    input  logic [$clog2(NUM_LOG)-1:0]  ren_src_b,
    input  logic                        ren_has_dst,
    input  logic [$clog2(NUM_LOG)-1:0]  ren_dst,
    output logic                        ren_ready,
    output logic [$clog2(NUM_PHYS)-1:0] ren_phys_a,
    output logic [$clog2(NUM_PHYS)-1:0] ren_phys_b,
    output logic [$clog2(NUM_PHYS)-1:0] ren_new_dst,
    output logic [$clog2(NUM_PHYS)-1:0] ren_old_dst,
    input  logic                        rel_valid,
    input  logic [$clog2(NUM_PHYS)-1:0] rel_phys
);
    localparam int PW = $clog2(NUM_PHYS);

    logic          filling, fill_push;
    logic [PW-1:0] fill_reg;
    logic          fl_empty, fl_push, accept, alloc;
    logic [PW-1:0] fl_push_reg, fl_head;
    logic [PW:0]   fl_count;

    rn_ctrl #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .filling   (filling),
        .fill_push (fill_push),
        .fill_reg  (fill_reg)
    );

    assign ren_ready   = !filling && (!ren_has_dst || !fl_empty);
    assign accept      = ren_valid && ren_ready;
    assign alloc       = accept && ren_has_dst;
    assign fl_push     = fill_push || (!filling && rel_valid);
    assign fl_push_reg = filling ? fill_reg : rel_phys;

    rn_free_list #(.NUM_PHYS(NUM_PHYS)) u_fl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fl_push),
        .push_reg (fl_push_reg),
        .pop      (alloc),
        .head_reg (fl_head),
        .empty    (fl_empty),
        .count    (fl_count)
    );

    rn_map_table #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_a  (ren_src_a),
        .rd_b  (ren_src_b),
        .rd_d  (ren_dst),
        .q_a   (ren_phys_a),
        .q_b   (ren_phys_b),
        .q_d   (ren_old_dst),
        .we    (alloc),
        .wa    (ren_dst),
        .wd    (fl_head)
    );

    assign ren_new_dst = fl_head;
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        filling,
    input logic                        fl_empty,
    input logic [$clog2(NUM_PHYS):0]   fl_count,
    input logic                        ren_valid,
    input logic                        ren_has_dst,
    input logic                        ren_ready,
    input logic [$clog2(NUM_PHYS)-1:0] ren_new_dst,
    input logic [$clog2(NUM_PHYS)-1:0] ren_old_dst,
    input logic                        rel_valid
);
    localparam int SPARE = NUM_PHYS - NUM_LOG;

    // R1
    fill_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filling |-> !ren_ready);

    // R7
    empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_empty && ren_has_dst) |-> !ren_ready);

    // R5
    fresh_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_has_dst) |-> (ren_new_dst != ren_old_dst));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!filling && !ren_valid && !rel_valid) |=> $stable(fl_count));

    // R6
    no_dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!filling && ren_valid && !ren_has_dst && !rel_valid) |=> $stable(fl_count));

    // R8
    release_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!filling && rel_valid && !(ren_valid && ren_ready && ren_has_dst))
        |=> (fl_count == $past(fl_count) + 1'b1));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_count <= ($clog2(NUM_PHYS) + 1)'(SPARE));
endmodule

bind rn_rename rn_rename_chk #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .filling     (filling),
    .fl_empty    (fl_empty),
    .fl_count    (fl_count),
    .ren_valid   (ren_valid),
    .ren_has_dst (ren_has_dst),
    .ren_ready   (ren_ready),
    .ren_new_dst (ren_new_dst),
    .ren_old_dst (ren_old_dst),
    .rel_valid   (rel_valid)
);

// File: tb/sim_rn_rename.sv
`timescale 1ns/1ps
module sim_rn_rename;
    localparam int NL = 4;
    localparam int NP = 8;

    typedef struct packed {
        logic       v;
        logic       hd;
        logic [1:0] sa;
        logic [1:0] sb;
        logic [1:0] d;
        logic       rv;
        logic [2:0] rp;
        logic [3:0] req;
    } vec_t;

    // stimulus; expected values come from the requirement model below
    localparam vec_t VECS [12] = '{
        '{1'b1, 1'b0, 2'd0, 2'd3, 2'd0, 1'b0, 3'd0, 4'd2},
        '{1'b1, 1'b1, 2'd3, 2'd3, 2'd3, 1'b0, 3'd0, 4'd4},
        '{1'b1, 1'b0, 2'd3, 2'd1, 2'd0, 1'b0, 3'd0, 4'd5},
        '{1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b0, 3'd0, 4'd9},
        '{1'b1, 1'b1, 2'd0, 2'd2, 2'd0, 1'b0, 3'd0, 4'd3},
        '{1'b1, 1'b1, 2'd1, 2'd0, 2'd1, 1'b1, 3'd3, 4'd5},
        '{1'b1, 1'b1, 2'd2, 2'd1, 2'd2, 1'b0, 3'd0, 4'd5},
        '{1'b1, 1'b1, 2'd3, 2'd2, 2'd3, 1'b0, 3'd0, 4'd8},
        '{1'b1, 1'b0, 2'd1, 2'd2, 2'd0, 1'b0, 3'd0, 4'd7},
        '{1'b1, 1'b1, 2'd1, 2'd3, 2'd1, 1'b1, 3'd0, 4'd7},
        '{1'b1, 1'b1, 2'd1, 2'd0, 2'd1, 1'b1, 3'd4, 4'd8},
        '{1'b1, 1'b1, 2'd2, 2'd1, 2'd2, 1'b0, 3'd0, 4'd8}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0, ren_has_dst = 1'b0, rel_valid = 1'b0;
    logic [1:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic [2:0] rel_phys = '0;
    logic       ren_ready;
    logic [2:0] ren_phys_a, ren_phys_b, ren_new_dst, ren_old_dst;

    int n_chk = 0, n_fail = 0;
    int m_map [NL];
    int m_fl [64];
    int m_head, m_tail;

    always #5 clk = ~clk;

    rn_rename #(.NUM_LOG(NL), .NUM_PHYS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src_a(ren_src_a),
        .ren_src_b(ren_src_b), .ren_has_dst(ren_has_dst), .ren_dst(ren_dst),
        .ren_ready(ren_ready), .ren_phys_a(ren_phys_a), .ren_phys_b(ren_phys_b),
        .ren_new_dst(ren_new_dst), .ren_old_dst(ren_old_dst),
        .rel_valid(rel_valid), .rel_phys(rel_phys)
    );

    function automatic string rtag(int n);
        case (n)
            1: return "R1"; 2: return "R2"; 3: return "R3";
            4: return "R4"; 5: return "R5"; 6: return "R6";
            7: return "R7"; 8: return "R8"; default: return "R9";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NL; i++) m_map[i] = i;
        m_head = 0;
        m_tail = 0;
        for (int i = NL; i < NP; i++) begin m_fl[m_tail] = i; m_tail++; end
    endtask

    task automatic run_vec(vec_t x);
        bit exp_rdy;
        @(negedge clk);
        ren_valid = x.v; ren_has_dst = x.hd; ren_src_a = x.sa; ren_src_b = x.sb;
        ren_dst = x.d; rel_valid = x.rv; rel_phys = x.rp;
        #1;
        exp_rdy = !x.hd || (m_tail != m_head);
        check(ren_ready == exp_rdy, "R7", "ready", ren_ready, exp_rdy);
        if (x.v) begin
            check(ren_phys_a == m_map[x.sa], rtag(x.req), "phys_a", ren_phys_a, m_map[x.sa]);
            check(ren_phys_b == m_map[x.sb], rtag(x.req), "phys_b", ren_phys_b, m_map[x.sb]);
        end
        if (x.v && x.hd && exp_rdy) begin
            check(ren_old_dst == m_map[x.d], rtag(x.req), "old_dst", ren_old_dst, m_map[x.d]);
            check(ren_new_dst == m_fl[m_head], rtag(x.req), "new_dst", ren_new_dst, m_fl[m_head]);
            m_map[x.d] = m_fl[m_head];
            m_head++;
        end
        if (x.rv) begin m_fl[m_tail] = x.rp; m_tail++; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ren_valid = 1'b0; rel_valid = 1'b0; ren_has_dst = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        // R1: not ready for NP-NL cycles, then ready
        for (int c = 0; c < NP - NL; c++) begin
            check(ren_ready == 1'b0, "R1", "ready during fill", ren_ready, 0);
            @(negedge clk); #1;
        end
        check(ren_ready == 1'b1, "R1", "ready after fill", ren_ready, 1);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        foreach (VECS[i]) run_vec(VECS[i]);
        // R2 / R3: a second reset restores identity map and ascending queue
        do_reset();
        run_vec('{1'b1, 1'b0, 2'd3, 2'd2, 2'd0, 1'b0, 3'd0, 4'd2});
        run_vec('{1'b1, 1'b1, 2'd1, 2'd0, 2'd1, 1'b0, 3'd0, 4'd3});
        run_vec('{1'b1, 1'b1, 2'd1, 2'd1, 2'd2, 1'b0, 3'd0, 4'd3});
        @(negedge clk);
        ren_valid = 1'b0; rel_valid = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule